// File: doc/BRIEF.md
# Sixteen-bit compare timer with fast-PWM wrap

This block is a 16-bit up-counter with two compare channels (A and B), an overflow flag and two interrupt request lines. A control register pair selects the counting mode, and a mask register enables each compare interrupt. All state is loaded through a simple byte-wide write port. A `tick` input advances the counter by a fixed step each cycle it is high, so the block can sit behind any prescaler.

Two modes are modelled. In normal mode the counter runs freely and sets the overflow flag when it wraps past 0xFFFF. In fast-PWM mode the compare A value is the period: when the count equals compare A on a tick, the counter reloads to zero and the overflow flag is set. On a tick where the count is zero, the flag is cleared again. In both modes each compare channel raises its interrupt line on a match when enabled, and drops it on a tick at count zero.

Top module: `pwm16_timer`

## Requirements
- R1: A synchronous reset (`rst` high) clears the counter, the overflow flag, both interrupt lines, both control registers, both compare registers and the mask, so that after reset a tick at count 0 raises no interrupt.
- R2: The 4-bit mode is {control B bits [4:3], control A bits [1:0]}. Only the value 4'b1111 selects fast-PWM with compare A as top. Every other value, including control A = 0x03 with control B = 0, counts as normal mode.
- R3: In normal mode, the count seen one cycle after a tick is the previous count plus the step (1 by default). With `tick` low and no counter write, the count holds.
- R4: In normal mode, a tick at count 0xFFFF gives count 0 and sets the overflow flag. The flag stays set through later normal-mode ticks.
- R5: In fast-PWM mode, a tick at a count equal to compare A gives count 0 on the next cycle, with no step added, and sets the overflow flag.
- R6: In fast-PWM mode, a tick at count 0 that is not a compare A match clears the overflow flag. When compare A is 0, the match takes priority: the count stays 0 and the flag is set.
- R7: On a tick where the count equals a channel's compare value, that channel's interrupt line goes high on the next cycle only if its mask bit is set (bit 1 for A, bit 2 for B). With the mask bit clear, the line does not rise.
- R8: On a tick at count 0 that is not a match for the channel, an enabled channel's interrupt line goes low. Otherwise the line holds its value.
- R9: Write addresses: 0 control A, 1 control B, 2 count low, 3 count high, 4/5 compare A low/high, 6/7 compare B low/high, 8 mask, 9 flag. A counter byte write overrides any tick in the same cycle.
- R10: Writing the flag address with bit 0 set clears the overflow flag, unless the flag is being set by a tick in that same cycle, in which case it ends set.
- R11: Writes to the control registers and the mask take effect from the first tick after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current counter value |
| ovf | output | 1 | Overflow flag |
| irq_a | output | 1 | Compare A interrupt request |
| irq_b | output | 1 | Compare B interrupt request |

## Verification
The bench sets only one half of the mode field at a time. A design that decoded the mode from a single register would wrap at compare A too early, or would fail to wrap. It drives the count through 0xFFFF and through zero in both modes, which catches a flag that is cleared in normal mode or not set at the period boundary. With compare A set to zero, a design that gives the zero-count clear priority over the match would drop the overflow flag. It also tries a flag clear and a counter write in the same cycle as a tick: getting the priority wrong there loses a period event or lets the step corrupt the written count.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] AD_CTLA  = 4'd0;
  localparam logic [ADDR_W-1:0] AD_CTLB  = 4'd1;
  localparam logic [ADDR_W-1:0] AD_CNTL  = 4'd2;
  localparam logic [ADDR_W-1:0] AD_CNTH  = 4'd3;
  localparam int                CMP_BASE = 4;   // A low/high at 4/5, B at 6/7
  localparam logic [ADDR_W-1:0] AD_MASK  = 4'd8;
  localparam logic [ADDR_W-1:0] AD_FLAG  = 4'd9;
  localparam int                NUM_CH   = 2;
  localparam logic [3:0]        MODE_FPWM_TOPA = 4'b1111;
endpackage

// File: rtl/pwm16_regfile.sv
module pwm16_regfile
  import pwm16_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [3:0]        mode,
  output logic [DW-1:0]     mask,
  output logic [CW-1:0]     cmp [NUM_CH]
);
  logic [DW-1:0] ctl_a_q, ctl_b_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AD_CTLA) ctl_a_q <= wr_data;
      if (wr_addr == AD_CTLB) ctl_b_q <= wr_data;
      if (wr_addr == AD_MASK) mask_q  <= wr_data;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    localparam logic [ADDR_W-1:0] AD_LO = ADDR_W'(CMP_BASE + 2 * ch);
    localparam logic [ADDR_W-1:0] AD_HI = ADDR_W'(CMP_BASE + 2 * ch + 1);
    logic [CW-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == AD_LO) cmp_q[DW-1:0]  <= wr_data;
        if (wr_addr == AD_HI) cmp_q[CW-1:DW] <= wr_data;
      end
    end
    assign cmp[ch] = cmp_q;
  end

  assign mode = {ctl_b_q[4:3], ctl_a_q[1:0]};
  assign mask = mask_q;
endmodule

// File: rtl/pwm16_counter.sv
module pwm16_counter
  import pwm16_pkg::*;
#(
  parameter int DW  = 8,
  parameter int INC = 1,
  parameter int CLR_BIT = 0,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pwm_mode,
  input  logic [CW-1:0]     top,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CW-1:0]     count,
  output logic              ovf
);
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic [CW:0]   sum;
  logic          at_top, at_zero, set_ovf, clr_zero, clr_sw;

  assign sum      = {1'b0, cnt_q} + (CW+1)'(INC);
  assign at_top   = pwm_mode && (cnt_q == top);
  assign at_zero  = (cnt_q == '0);
  assign set_ovf  = tick && (at_top || (!pwm_mode && sum[CW]));
  assign clr_zero = tick && pwm_mode && at_zero && !at_top;
  assign clr_sw   = wr_en && (wr_addr == AD_FLAG) && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (set_ovf)                 ovf_q <= 1'b1;
      else if (clr_zero || clr_sw) ovf_q <= 1'b0;
      if (tick) cnt_q <= at_top ? '0 : sum[CW-1:0];
      if (wr_en && wr_addr == AD_CNTL) cnt_q[DW-1:0]  <= wr_data;
      if (wr_en && wr_addr == AD_CNTH) cnt_q[CW-1:DW] <= wr_data;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/pwm16_cmp_ch.sv
module pwm16_cmp_ch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp,
  input  logic          en,
  output logic          irq
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (tick && en) begin
      if (count == cmp)      irq_q <= 1'b1;
      else if (count == '0)  irq_q <= 1'b0;
    end
  end
  assign irq = irq_q;
endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
  import pwm16_pkg::*;
#(
  parameter int DW       = 8,
  parameter int INC      = 1,
  parameter int EN_A_BIT = 1,
  parameter int EN_B_BIT = 2,
  parameter int CLR_BIT  = 0,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CW-1:0]     count,
  output logic              ovf,
  output logic              irq_a,
  output logic              irq_b
);
  logic [3:0]    mode;
  logic [DW-1:0] mask;
  logic [CW-1:0] cmp [NUM_CH];
  logic [CW-1:0] cmp_a;
  logic          en_a, en_b;
  logic [NUM_CH-1:0] en_v, irq_v;

  pwm16_regfile #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .mask(mask), .cmp(cmp)
  );

  assign cmp_a = cmp[0];
  assign en_a  = mask[EN_A_BIT];
  assign en_b  = mask[EN_B_BIT];
  assign en_v  = {en_b, en_a};

  pwm16_counter #(.DW(DW), .INC(INC), .CLR_BIT(CLR_BIT)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .pwm_mode(mode == MODE_FPWM_TOPA),
    .top(cmp_a), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ovf(ovf)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm16_cmp_ch #(.CW(CW)) ch_i (
      .clk(clk), .rst(rst), .tick(tick), .count(count), .cmp(cmp[ch]),
      .en(en_v[ch]), .irq(irq_v[ch])
    );
  end

  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];
endmodule

// File: rtl/pwm16_timer_chk.sv
module pwm16_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [15:0] count,
  input logic        ovf,
  input logic        irq_a,
  input logic        irq_b,
  input logic [3:0]  mode,
  input logic [15:0] cmp_a,
  input logic        en_a
);
  logic wr_cnt, pwm;
  assign wr_cnt = wr_en && (wr_addr == 4'd2 || wr_addr == 4'd3);
  assign pwm    = (mode == 4'b1111);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (count == 16'h0 && !ovf && !irq_a && !irq_b));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !pwm && !wr_cnt) |=> count == 16'($past(count) + 16'd1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(count));

  // R4
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !pwm && !wr_cnt && count == 16'hFFFF) |=> (count == 16'h0 && ovf));

  // R5
  top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && pwm && !wr_cnt && count == cmp_a) |=> (count == 16'h0 && ovf));

  // R7
  irq_a_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_a) |-> $past(en_a));

  // R8
  irq_a_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && en_a && count == 16'h0 && cmp_a != 16'h0) |=> !irq_a);
endmodule

bind pwm16_timer pwm16_timer_chk chk_i (.*);

// File: tb/pwm16_timer_tb_top.sv
module pwm16_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic ovf, irq_a, irq_b;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm16_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .ovf(ovf), .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic [7:0]  data;
    logic [7:0]  nt;
    logic [15:0] cnt;
    logic        ov;
    logic        ia;
    logic        ib;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{4'd4, 8'h05, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 compare A low
    '{4'd6, 8'h03, 8'd3, 16'h0003, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 masked match on B
    '{4'd8, 8'h04, 8'd1, 16'h0004, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 B enabled match
    '{4'd8, 8'h06, 8'd1, 16'h0005, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{4'd0, 8'h03, 8'd1, 16'h0006, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 half mode stays normal
    '{4'd1, 8'h18, 8'd0, 16'h0006, 1'b0, 1'b1, 1'b1, 4'd11}, // R11
    '{4'd2, 8'h05, 8'd0, 16'h0005, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 count low
    '{4'd8, 8'h06, 8'd1, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 wrap at top
    '{4'd8, 8'h06, 8'd1, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 and R8 at zero
    '{4'd8, 8'h02, 8'd4, 16'h0005, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 B masked
    '{4'd8, 8'h02, 8'd1, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{4'd9, 8'h01, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10
    '{4'd1, 8'h00, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 back to normal
    '{4'd3, 8'hFF, 8'd0, 16'hFF00, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 count high
    '{4'd2, 8'hFE, 8'd1, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{4'd8, 8'h02, 8'd1, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 wrap sets flag
    '{4'd8, 8'h02, 8'd1, 16'h0001, 1'b1, 1'b0, 1'b0, 4'd8}   // R8, R4 flag sticky
  };

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic [15:0] c, input logic o, input logic a, input logic b);
    chk(req, "count", count, c);
    chk(req, "ovf",   {15'b0, ovf},   {15'b0, o});
    chk(req, "irq_a", {15'b0, irq_a}, {15'b0, a});
    chk(req, "irq_b", {15'b0, irq_b}, {15'b0, b});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic t);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    chk_all(1, 16'h0000, 0, 0, 0);  // R1

    for (int v = 0; v < NV; v++) begin
      wr(TBL[v].addr, TBL[v].data, 1'b0);
      run(int'(TBL[v].nt));
      chk_all(int'(TBL[v].req), TBL[v].cnt, TBL[v].ov, TBL[v].ia, TBL[v].ib);
    end

    // R1: reset mid-run clears registers too (mask 0: no irq at count 0 match)
    do_reset();
    chk_all(1, 16'h0000, 0, 0, 0);
    run(1);
    chk_all(1, 16'h0001, 0, 0, 0);

    // R9: counter write beats tick in the same cycle
    wr(4'd2, 8'h40, 1'b1);
    chk(9, "count", count, 16'h0040);
    // R3: hold without tick
    repeat (3) @(negedge clk);
    chk(3, "count", count, 16'h0040);

    // R6: fast-PWM with compare A = 0, match wins at zero
    wr(4'd0, 8'h03, 1'b0);
    wr(4'd1, 8'h18, 1'b0);
    wr(4'd2, 8'h00, 1'b0);
    run(1);
    chk(6, "count", count, 16'h0000);
    chk(6, "ovf", {15'b0, ovf}, 16'h0001);
    run(1);
    chk(6, "ovf", {15'b0, ovf}, 16'h0001);

    // R6: top of 2, tick at zero clears flag
    wr(4'd4, 8'h02, 1'b0);
    run(2);
    chk(6, "count", count, 16'h0002);
    chk(6, "ovf", {15'b0, ovf}, 16'h0000);
    // R10: flag clear in the same cycle as a period event leaves it set
    wr(4'd9, 8'h01, 1'b1);
    chk(10, "count", count, 16'h0000);
    chk(10, "ovf", {15'b0, ovf}, 16'h0001);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule